// File: doc/BRIEF.md
# Exception Cause Priority Selector

This combinational block resolves the synchronous faults that a single instruction can raise at once into one trap request. Each candidate fault arrives on its own flag. The block picks the most urgent flag under a fixed ordering and reports three things: that a trap is due, its 32-bit cause value, and a one-hot vector naming the winning fault. Faults cannot be switched off, so no enable input masks any of them.

Three faults come from the fetch side: the instruction access fault, the instruction parity/checksum fault and the instruction bus fault. These only matter if the instruction is actually executed. A single qualifier input, `i_exec_attempt`, removes them from the ordering when no execution attempt is made. The faults raised at decode and at memory access are never qualified.

The block has no handshake. The outputs follow the inputs within the same cycle and carry no state. The pipeline stage around the block decides when the result is consumed.

Top module: `exc_cause_sel`

## Requirements
- R1: When exactly one qualified flag is set, the cause output carries that fault's code. The codes are: access fault 1, illegal instruction 2, breakpoint 3, load access fault 5, store/AMO access fault 7, user environment call 8, machine environment call 11, fetch bus fault 24, fetch parity/checksum fault 25.
- R2: When several qualified flags are set, the code reported is the earliest one in this list, highest priority first: 1, 25, 24, 2, 8, 11, 3, 7, 5.
- R3: Bit 31 of the cause output (the interrupt marker) is always 0.
- R4: With `i_exec_attempt` low, the access, parity/checksum and bus fetch flags have no effect on any output. With it high, they take part normally.
- R5: With no qualified flag set, `o_trap_valid` is 0, the cause output is all zeros and the one-hot output is all zeros.
- R6: The one-hot output has exactly one bit set whenever `o_trap_valid` is 1. Its bit position is the priority rank, with bit 0 the highest. In rank order the bits are: access 0, parity/checksum 1, fetch bus 2, illegal 3, user call 4, machine call 5, breakpoint 6, store 7, load 8.
- R7: The illegal instruction, environment call, breakpoint, store and load flags raise a trap whatever the value of `i_exec_attempt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_exec_attempt | input | 1 | The instruction is actually being executed. This qualifies the fetch-side faults. |
| i_fetch_access_fault | input | 1 | The fetch failed its protection or attribute check. |
| i_fetch_parity_fault | input | 1 | The fetched word failed its parity/checksum check. |
| i_fetch_bus_fault | input | 1 | The fetch returned a bus error. |
| i_illegal_instr | input | 1 | The instruction decoded as illegal. |
| i_ecall_user | input | 1 | Environment call made in user mode. |
| i_ecall_mach | input | 1 | Environment call made in machine mode. |
| i_ebreak | input | 1 | Environment break. |
| i_store_access_fault | input | 1 | The store or atomic access was refused. |
| i_load_access_fault | input | 1 | The load access was refused. |
| o_trap_valid | output | 1 | A trap is requested. |
| o_trap_cause | output | CAUSE_W (32) | Cause code of the winning fault. Bit 31 is always clear. |
| o_trap_onehot | output | 9 | One-hot flag for the winning fault, in priority rank order. |

## Verification
Each flag is first driven alone, which shows that every code and every one-hot position is wired to the right input. All 36 two-flag combinations are then applied with the qualifier high. These show the full pairwise ordering, including the unusual placement of codes 25 and 24 just below code 1. The same 36 pairs are repeated with the qualifier low. Here a pair of fetch faults must give no trap, while a fetch fault paired with a decode fault must yield the decode fault's code. Together these separate missing gating from gating applied to the wrong flags. The empty pattern and a pattern with every flag set cover the two ends of the range.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;

  // Number of synchronous fault sources, indexed by priority rank (0 = most urgent)
  localparam int unsigned NUM_EXC = 9;

  typedef enum logic [3:0] {
    RANK_FETCH_ACCESS = 4'd0,
    RANK_FETCH_PARITY = 4'd1,
    RANK_FETCH_BUS    = 4'd2,
    RANK_ILLEGAL      = 4'd3,
    RANK_ECALL_U      = 4'd4,
    RANK_ECALL_M      = 4'd5,
    RANK_EBREAK       = 4'd6,
    RANK_STORE        = 4'd7,
    RANK_LOAD         = 4'd8
  } exc_rank_e;

  // Ranks that belong to the fetch stage and need an execution attempt
  localparam logic [NUM_EXC-1:0] FETCH_SIDE_MASK = 9'b0_0000_0111;

  localparam int unsigned CODE_W = 5;

  function automatic logic [CODE_W-1:0] rank_to_code(input int unsigned rank);
    logic [CODE_W-1:0] code;
    case (rank)
      RANK_FETCH_ACCESS: code = 5'd1;
      RANK_FETCH_PARITY: code = 5'd25;
      RANK_FETCH_BUS:    code = 5'd24;
      RANK_ILLEGAL:      code = 5'd2;
      RANK_ECALL_U:      code = 5'd8;
      RANK_ECALL_M:      code = 5'd11;
      RANK_EBREAK:       code = 5'd3;
      RANK_STORE:        code = 5'd7;
      RANK_LOAD:         code = 5'd5;
      default:           code = '0;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/exc_fetch_gate.sv
module exc_fetch_gate #(
  parameter int unsigned              N    = 9,
  parameter logic [N-1:0]             MASK = '0
) (
  input  logic         exec_attempt,
  input  logic [N-1:0] raw_flags,
  output logic [N-1:0] qual_flags
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    if (MASK[g]) begin : g_fetch
      assign qual_flags[g] = raw_flags[g] & exec_attempt;
    end else begin : g_pass
      assign qual_flags[g] = raw_flags[g];
    end
  end

endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  // Lowest index wins; a running "already taken" bit blocks later ranks
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int unsigned i = 0; i < N; i++) begin
      grant[i] = req[i] & ~taken;
      taken    = taken | req[i];
    end
  end

endmodule

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
  import exc_sel_pkg::*;
#(
  parameter int unsigned N       = NUM_EXC,
  parameter int unsigned CAUSE_W = 32
) (
  input  logic [N-1:0]       onehot,
  output logic [CAUSE_W-1:0] cause
);

  localparam int unsigned PAD_W = CAUSE_W - CODE_W;

  logic [CODE_W-1:0] term [N];

  for (genvar g = 0; g < N; g++) begin : g_term
    assign term[g] = onehot[g] ? rank_to_code(g) : '0;
  end

  logic [CODE_W-1:0] code_or;
  always_comb begin
    code_or = '0;
    for (int unsigned i = 0; i < N; i++) begin
      code_or = code_or | term[i];
    end
  end

  // Upper bits, including the interrupt marker, stay zero for synchronous faults
  assign cause = {{PAD_W{1'b0}}, code_or};

endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_sel_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32
) (
  input  logic               i_exec_attempt,
  input  logic               i_fetch_access_fault,
  input  logic               i_fetch_parity_fault,
  input  logic               i_fetch_bus_fault,
  input  logic               i_illegal_instr,
  input  logic               i_ecall_user,
  input  logic               i_ecall_mach,
  input  logic               i_ebreak,
  input  logic               i_store_access_fault,
  input  logic               i_load_access_fault,
  output logic               o_trap_valid,
  output logic [CAUSE_W-1:0] o_trap_cause,
  output logic [NUM_EXC-1:0] o_trap_onehot
);

  logic [NUM_EXC-1:0] raw_flags;
  logic [NUM_EXC-1:0] qual_flags;
  logic [NUM_EXC-1:0] grant;

  // Pack the flags by priority rank
  always_comb begin
    raw_flags                    = '0;
    raw_flags[RANK_FETCH_ACCESS] = i_fetch_access_fault;
    raw_flags[RANK_FETCH_PARITY] = i_fetch_parity_fault;
    raw_flags[RANK_FETCH_BUS]    = i_fetch_bus_fault;
    raw_flags[RANK_ILLEGAL]      = i_illegal_instr;
    raw_flags[RANK_ECALL_U]      = i_ecall_user;
    raw_flags[RANK_ECALL_M]      = i_ecall_mach;
    raw_flags[RANK_EBREAK]       = i_ebreak;
    raw_flags[RANK_STORE]        = i_store_access_fault;
    raw_flags[RANK_LOAD]         = i_load_access_fault;
  end

  exc_fetch_gate #(
    .N    (NUM_EXC),
    .MASK (FETCH_SIDE_MASK)
  ) i_gate (
    .exec_attempt (i_exec_attempt),
    .raw_flags    (raw_flags),
    .qual_flags   (qual_flags)
  );

  exc_prio_pick #(
    .N (NUM_EXC)
  ) i_pick (
    .req   (qual_flags),
    .grant (grant)
  );

  exc_cause_enc #(
    .N       (NUM_EXC),
    .CAUSE_W (CAUSE_W)
  ) i_enc (
    .onehot (grant),
    .cause  (o_trap_cause)
  );

  assign o_trap_onehot = grant;
  assign o_trap_valid  = |grant;

endmodule

// File: rtl/exc_cause_sel_chk.sv
module exc_cause_sel_chk
  import exc_sel_pkg::*;
#(
  parameter int unsigned CAUSE_W = 32
) (
  input logic               i_exec_attempt,
  input logic               i_fetch_access_fault,
  input logic               i_fetch_parity_fault,
  input logic               i_fetch_bus_fault,
  input logic               i_illegal_instr,
  input logic               i_ecall_user,
  input logic               i_ecall_mach,
  input logic               i_ebreak,
  input logic               i_store_access_fault,
  input logic               i_load_access_fault,
  input logic               o_trap_valid,
  input logic [CAUSE_W-1:0] o_trap_cause,
  input logic [NUM_EXC-1:0] o_trap_onehot
);

  logic any_decode;
  assign any_decode = i_illegal_instr | i_ecall_user | i_ecall_mach | i_ebreak |
                      i_store_access_fault | i_load_access_fault;

  always_comb begin
    AST_ONEHOT_WINNER: assert ($onehot0(o_trap_onehot) &&
                               (o_trap_valid == ($countones(o_trap_onehot) == 1)))
      else $error("winner vector not one-hot with valid"); // R6
    AST_INT_BIT_CLEAR: assert (o_trap_cause[CAUSE_W-1] == 1'b0)
      else $error("interrupt marker set"); // R3
    if (!o_trap_valid) begin
      AST_IDLE_ZERO: assert (o_trap_cause == '0)
        else $error("cause nonzero while idle"); // R5
    end
    if (!i_exec_attempt && !any_decode) begin
      AST_FETCH_GATED: assert (!o_trap_valid)
        else $error("fetch fault trapped without execution"); // R4
    end
    if (i_exec_attempt && i_fetch_access_fault) begin
      AST_ACCESS_TOP: assert (o_trap_cause == CAUSE_W'(1))
        else $error("access fault not top priority"); // R2
    end
    if (any_decode) begin
      AST_DECODE_ALWAYS: assert (o_trap_valid)
        else $error("decode-side fault dropped"); // R7
    end
  end

endmodule

bind exc_cause_sel exc_cause_sel_chk #(.CAUSE_W(CAUSE_W)) i_chk (.*);

// File: tb/test_exc_cause_sel.sv
module test_exc_cause_sel;

  localparam int unsigned N  = 9;
  localparam int unsigned CW = 32;

  // Cause code by priority rank (R1, R2)
  localparam logic [CW-1:0] RANK_CODE [N] = '{
    32'd1, 32'd25, 32'd24, 32'd2, 32'd8, 32'd11, 32'd3, 32'd7, 32'd5
  };
  localparam logic [N-1:0] FETCH_BITS = 9'b0_0000_0111;

  // Stimulus table: flags (rank order), exec qualifier, expected cause (0 = no trap)
  localparam int unsigned NV = 16;
  localparam logic [N-1:0] TV_FLAGS [NV] = '{
    9'h001, 9'h002, 9'h004, 9'h008, 9'h010, 9'h020, 9'h040, 9'h080, 9'h100,
    9'h001, 9'h002, 9'h004, 9'h1F8, 9'h1FF, 9'h1FF, 9'h180
  };
  localparam logic TV_EXEC [NV] = '{
    1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0
  };
  localparam logic [CW-1:0] TV_CAUSE [NV] = '{
    32'd1, 32'd25, 32'd24, 32'd2, 32'd8, 32'd11, 32'd3, 32'd7, 32'd5,
    32'd0, 32'd0, 32'd0, 32'd2, 32'd1, 32'd2, 32'd7
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]  flags = '0;
  logic          exec  = 1'b0;
  logic          trap_valid;
  logic [CW-1:0] trap_cause;
  logic [N-1:0]  trap_onehot;

  int checks = 0;
  int errors = 0;

  exc_cause_sel #(.CAUSE_W(CW)) i_exc_cause_sel (
    .i_exec_attempt       (exec),
    .i_fetch_access_fault (flags[0]),
    .i_fetch_parity_fault (flags[1]),
    .i_fetch_bus_fault    (flags[2]),
    .i_illegal_instr      (flags[3]),
    .i_ecall_user         (flags[4]),
    .i_ecall_mach         (flags[5]),
    .i_ebreak             (flags[6]),
    .i_store_access_fault (flags[7]),
    .i_load_access_fault  (flags[8]),
    .o_trap_valid         (trap_valid),
    .o_trap_cause         (trap_cause),
    .o_trap_onehot        (trap_onehot)
  );

  function automatic logic [CW-1:0] onehot_of(input logic [CW-1:0] code);
    for (int r = 0; r < N; r++) if (RANK_CODE[r] == code && code != 0) return CW'(1) << r;
    return '0;
  endfunction

  task automatic check(input logic [N-1:0] f, input logic e,
                       input logic [CW-1:0] exp_cause, input string req);
    logic [N-1:0] exp_oh;
    @(negedge clk);
    flags = f;
    exec  = e;
    #1;
    exp_oh = N'(onehot_of(exp_cause));
    checks++;
    if (trap_valid !== (exp_cause != 0) || trap_cause !== exp_cause ||
        trap_onehot !== exp_oh || trap_cause[CW-1] !== 1'b0) begin
      errors++;
      $display("FAIL %s flags=%b exec=%0b: valid=%0b cause=%0d onehot=%b expected valid=%0b cause=%0d onehot=%b",
               req, f, e, trap_valid, trap_cause, trap_onehot,
               exp_cause != 0, exp_cause, exp_oh);
    end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R5: idle state after reset, no flags
    check('0, 1'b0, '0, "R5 reset idle");
    check('0, 1'b1, '0, "R5 idle with exec");

    // Table walk: R1 singles, R4 gating, R7 decode-side unqualified, R3 implicit
    for (int v = 0; v < NV; v++) begin
      check(TV_FLAGS[v], TV_EXEC[v], TV_CAUSE[v],
            (v < 9) ? "R1 single code" : "R4/R7 table");
    end

    // R2, R6: every pair with exec high, higher rank must win
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        check((N'(1) << a) | (N'(1) << b), 1'b1, RANK_CODE[a], "R2 pair order");
      end
    end

    // R4, R7: every pair with exec low, fetch ranks drop out
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        logic [CW-1:0] exp;
        if (!FETCH_BITS[a])      exp = RANK_CODE[a];
        else if (!FETCH_BITS[b]) exp = RANK_CODE[b];
        else                     exp = '0;
        check((N'(1) << a) | (N'(1) << b), 1'b0, exp, "R4 pair gated");
      end
    end

    // R3: top code with all decode flags and exec toggled back high
    check(9'h1FE, 1'b1, 32'd25, "R3 parity beats rest");
    check(9'h000, 1'b1, '0, "R5 return to idle");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule